// File: doc/BRIEF.md
# SPI Rate-Sensor Register Slave

This block is the device side of a serial peripheral link that behaves like a two-axis angular-rate sensor, so that a host SPI master can be exercised against a realistic register file. The host opens a transaction by pulling chip select low. It then sends a command byte, followed by data bytes that are either written into configuration registers or read back from identification, rate, temperature and configuration registers.

Rate and temperature samples arrive on a parallel stream port, qualified by a valid strobe. The slave never back-pressures that port. Its ready output is held high permanently, and a sample offered while the sensor is in standby is accepted and then discarded. A data-ready output can be routed to a pin. It tells the host that a fresh sample is waiting, and it drops once the host has read the Y-rate register pair.

The serial inputs are asynchronous to `clk` and pass through synchronizers. SCLK must therefore stay at each level for at least four `clk` cycles.

Top module: `gyro_spi_regs`

## Requirements
- R1: The link uses SPI mode 3, MSB first: SCLK idles high, MOSI is sampled on rising edges and MISO changes after falling edges. The first byte is a command in which bit 7 = 1 means read, bit 7 = 0 means write, and bits [6:0] give the start address.
- R2: Address 0x00 reads 0xAD, 0x01 reads 0x1D and 0x02 reads 0x92. Address 0x03 reads the revision parameter (default 0x01). Addresses 0x04..0x07 read the serial parameter low byte first (default 0x5EC01234, giving 0x34, 0x12, 0xC0, 0x5E).
- R3: X rate sits at 0x08 (low byte) and 0x09 (high byte), Y rate at 0x0A/0x0B, and temperature at 0x0C/0x0D. Byte 0x0D carries temperature bits [11:8], sign-extended from bit 11 through bits [7:4]. All six bytes read 0 after reset.
- R4: Each byte after the first data byte of a transaction moves to the next address, for reads and for writes alike. A 6-byte read starting at 0x08 returns X low, X high, Y low, Y high, temperature low, temperature high.
- R5: Power register 0x10 resets to 0x00. Bit 1 = 1 selects measurement and bit 1 = 0 selects standby. Bit 0 enables temperature capture. Bits [7:2] read 0.
- R6: Filter register 0x11 resets to 0x00. It keeps the low-pass index in bits [2:0] and the high-pass index in bits [7:4]. Bit 3 reads 0.
- R7: Data-ready configuration register 0x12 resets to 0x00 and keeps bits [1:0]; bits [7:2] read 0. The data-ready flag reaches `drdy_out` only while bits [1:0] = 01; with any other value the pin stays low.
- R8: The data-ready flag is set by a sample accepted in measurement mode. It stays set until the byte at 0x0B has been fully shifted out in a read. If a sample arrives in the same cycle as that clear, the set takes precedence.
- R9: In standby, samples do not change any data register, and the data-ready flag is cleared and stays low.
- R10: With power bit 0 clear, a sample accepted in measurement mode updates X and Y but leaves the temperature unchanged.
- R11: A read transaction returns data captured at the end of its command byte. A sample that arrives during the burst does not affect that burst; it appears in the next transaction.
- R12: Raising chip select part-way through a byte discards the partial byte: no write happens, and the next transaction starts with a fresh command.
- R13: Writes to addresses other than 0x10, 0x11 and 0x12 have no effect.
- R14: `smp_ready` is high at all times after reset, and a sample is taken in any cycle where `smp_valid` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| spi_sclk | input | 1 | Serial clock from the host, idles high |
| spi_cs_n | input | 1 | Active-low chip select |
| spi_mosi | input | 1 | Serial data from the host |
| spi_miso | output | 1 | Serial data to the host, low when deselected |
| smp_valid | input | 1 | Sample strobe |
| smp_ready | output | 1 | Sample acceptance, always high |
| smp_rate_x | input | 16 | X angular rate, two's complement |
| smp_rate_y | input | 16 | Y angular rate, two's complement |
| smp_temp | input | 12 | Temperature, two's complement |
| drdy_out | output | 1 | Data-ready pin |

## Verification
The hardest case to reach is a sample landing inside an active read burst, after the shadow copy has been taken but before the Y-rate high byte has been clocked out. Only a carefully timed collision shows both that the burst keeps the old values and that the data-ready flag is cleared by the end of the Y pair, even though it was just set. The bench forks a 6-byte burst against a sample push timed to fall inside the X-rate bytes. It then reads again to confirm that the new values were kept. A separate partial-byte abort, with chip select raised after four clocks, shows that a half-received write is dropped.

// File: rtl/gyro_spi_pkg.sv
package gyro_spi_pkg;
  localparam int RATE_W = 16;
  localparam int TEMP_W = 12;

  localparam logic [6:0] A_VEND = 7'h00;
  localparam logic [6:0] A_SENS = 7'h01;
  localparam logic [6:0] A_PART = 7'h02;
  localparam logic [6:0] A_REV  = 7'h03;
  localparam logic [6:0] A_SN0  = 7'h04;
  localparam logic [6:0] A_SN1  = 7'h05;
  localparam logic [6:0] A_SN2  = 7'h06;
  localparam logic [6:0] A_SN3  = 7'h07;
  localparam logic [6:0] A_XL   = 7'h08;
  localparam logic [6:0] A_XH   = 7'h09;
  localparam logic [6:0] A_YL   = 7'h0A;
  localparam logic [6:0] A_YH   = 7'h0B;
  localparam logic [6:0] A_TL   = 7'h0C;
  localparam logic [6:0] A_TH   = 7'h0D;
  localparam logic [6:0] A_PWR  = 7'h10;
  localparam logic [6:0] A_FLT  = 7'h11;
  localparam logic [6:0] A_DRC  = 7'h12;

  localparam logic [7:0] ID_VEND = 8'hAD;
  localparam logic [7:0] ID_SENS = 8'h1D;
  localparam logic [7:0] ID_PART = 8'h92;

  localparam logic [7:0] PWR_MASK  = 8'h03;
  localparam logic [7:0] FLT_MASK  = 8'hF7;
  localparam logic [7:0] DRC_MASK  = 8'h03;
  localparam logic [1:0] DRC_ROUTE = 2'b01;

  typedef struct packed {
    logic [RATE_W-1:0] x;
    logic [RATE_W-1:0] y;
    logic [TEMP_W-1:0] t;
  } gyro_sample_t;
endpackage

// File: rtl/gyro_spi_phy.sv
module gyro_spi_phy #(
  parameter int SYNC_LEN = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       spi_sclk,
  input  logic       spi_cs_n,
  input  logic       spi_mosi,
  output logic       spi_miso,
  output logic       sel,
  output logic       rx_valid,
  output logic [7:0] rx_byte,
  input  logic       tx_load,
  input  logic [7:0] tx_byte
);
  localparam int NSIG = 3;
  localparam logic [NSIG-1:0] SYNC_RST = 3'b110;

  logic [NSIG-1:0] raw_in, synced;
  assign raw_in = {spi_sclk, spi_cs_n, spi_mosi};

  for (genvar g = 0; g < NSIG; g++) begin : g_sync
    logic [SYNC_LEN-1:0] chain;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain <= {SYNC_LEN{SYNC_RST[g]}};
      else        chain <= {chain[SYNC_LEN-2:0], raw_in[g]};
    end
    assign synced[g] = chain[SYNC_LEN-1];
  end

  logic s_sclk, s_cs_n, s_mosi, sclk_q;
  assign s_sclk = synced[2];
  assign s_cs_n = synced[1];
  assign s_mosi = synced[0];

  logic rise, fall;
  assign rise = s_sclk & ~sclk_q;
  assign fall = ~s_sclk & sclk_q;
  assign sel  = ~s_cs_n;

  logic [2:0] bit_cnt;
  logic [7:0] rx_sh, tx_sh;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_q   <= 1'b1;
      bit_cnt  <= '0;
      rx_sh    <= '0;
      tx_sh    <= '0;
      rx_valid <= 1'b0;
      rx_byte  <= '0;
    end else begin
      sclk_q   <= s_sclk;
      rx_valid <= 1'b0;
      if (!sel) begin
        bit_cnt <= '0;
        rx_sh   <= '0;
        tx_sh   <= '0;
      end else begin
        if (rise) begin
          rx_sh   <= {rx_sh[6:0], s_mosi};
          bit_cnt <= bit_cnt + 3'd1;
          if (bit_cnt == 3'd7) begin
            rx_valid <= 1'b1;
            rx_byte  <= {rx_sh[6:0], s_mosi};
          end
        end
        // the MSB of a freshly loaded byte is already on the line, so the
        // falling edge that opens a byte must not shift
        if (tx_load)                      tx_sh <= tx_byte;
        else if (fall && bit_cnt != 3'd0) tx_sh <= {tx_sh[6:0], 1'b0};
      end
    end
  end

  assign spi_miso = sel & tx_sh[7];
endmodule

// File: rtl/gyro_spi_regfile.sv
module gyro_spi_regfile
  import gyro_spi_pkg::*;
#(
  parameter logic [7:0]  REV_ID    = 8'h01,
  parameter logic [31:0] SERIAL_NO = 32'h5EC0_1234
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         smp_valid,
  input  gyro_sample_t smp,
  input  logic         snap,
  input  logic         wr_en,
  input  logic [6:0]   wr_addr,
  input  logic [7:0]   wr_data,
  input  logic [6:0]   rd_addr,
  input  logic         rd_clr,
  output logic [7:0]   rd_data,
  output logic         meas,
  output logic         drdy_out
);
  localparam int TEMP_PAD = 2*8 - TEMP_W;

  gyro_sample_t live, shadow;
  logic [7:0] pwr, flt, drc;
  logic       flag, accept;

  assign meas   = pwr[1];
  assign accept = smp_valid & meas;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      live   <= '0;
      shadow <= '0;
      pwr    <= '0;
      flt    <= '0;
      drc    <= '0;
      flag   <= 1'b0;
    end else begin
      if (accept) begin
        live.x <= smp.x;
        live.y <= smp.y;
        if (pwr[0]) live.t <= smp.t;
      end
      if (snap) shadow <= live;
      if (wr_en) begin
        case (wr_addr)
          A_PWR:   pwr <= wr_data & PWR_MASK;
          A_FLT:   flt <= wr_data & FLT_MASK;
          A_DRC:   drc <= wr_data & DRC_MASK;
          default: ;
        endcase
      end
      if (!meas)       flag <= 1'b0;
      else if (accept) flag <= 1'b1;
      else if (rd_clr) flag <= 1'b0;
    end
  end

  always_comb begin
    case (rd_addr)
      A_VEND: rd_data = ID_VEND;
      A_SENS: rd_data = ID_SENS;
      A_PART: rd_data = ID_PART;
      A_REV:  rd_data = REV_ID;
      A_SN0, A_SN1, A_SN2, A_SN3:
              rd_data = SERIAL_NO[{rd_addr[1:0], 3'b000} +: 8];
      A_XL:   rd_data = shadow.x[7:0];
      A_XH:   rd_data = shadow.x[15:8];
      A_YL:   rd_data = shadow.y[7:0];
      A_YH:   rd_data = shadow.y[15:8];
      A_TL:   rd_data = shadow.t[7:0];
      A_TH:   rd_data = {{TEMP_PAD{shadow.t[TEMP_W-1]}}, shadow.t[TEMP_W-1:8]};
      A_PWR:  rd_data = pwr;
      A_FLT:  rd_data = flt;
      A_DRC:  rd_data = drc;
      default: rd_data = 8'h00;
    endcase
  end

  assign drdy_out = flag & (drc[1:0] == DRC_ROUTE);
endmodule

// File: rtl/gyro_spi_regs.sv
module gyro_spi_regs
  import gyro_spi_pkg::*;
#(
  parameter int          SYNC_LEN  = 2,
  parameter logic [7:0]  REV_ID    = 8'h01,
  parameter logic [31:0] SERIAL_NO = 32'h5EC0_1234
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              spi_sclk,
  input  logic              spi_cs_n,
  input  logic              spi_mosi,
  output logic              spi_miso,
  input  logic              smp_valid,
  output logic              smp_ready,
  input  logic [RATE_W-1:0] smp_rate_x,
  input  logic [RATE_W-1:0] smp_rate_y,
  input  logic [TEMP_W-1:0] smp_temp,
  output logic              drdy_out
);
  logic       sel, rx_valid, tx_load;
  logic [7:0] rx_byte, rd_data;
  logic       phase_data, is_read, meas;
  logic [6:0] addr;
  logic       snap, wr_en, rd_clr;
  gyro_sample_t smp_in;

  assign smp_in    = '{x: smp_rate_x, y: smp_rate_y, t: smp_temp};
  assign smp_ready = rst_n;

  gyro_spi_phy #(.SYNC_LEN(SYNC_LEN)) i_phy (
    .clk(clk), .rst_n(rst_n),
    .spi_sclk(spi_sclk), .spi_cs_n(spi_cs_n), .spi_mosi(spi_mosi),
    .spi_miso(spi_miso), .sel(sel),
    .rx_valid(rx_valid), .rx_byte(rx_byte),
    .tx_load(tx_load), .tx_byte(rd_data)
  );

  // command byte opens the data phase; data bytes step the address
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_data <= 1'b0;
      is_read    <= 1'b0;
      addr       <= '0;
      tx_load    <= 1'b0;
    end else if (!sel) begin
      phase_data <= 1'b0;
      is_read    <= 1'b0;
      tx_load    <= 1'b0;
    end else begin
      tx_load <= 1'b0;
      if (rx_valid) begin
        if (!phase_data) begin
          phase_data <= 1'b1;
          is_read    <= rx_byte[7];
          addr       <= rx_byte[6:0];
          tx_load    <= rx_byte[7];
        end else begin
          addr    <= addr + 7'd1;
          tx_load <= is_read;
        end
      end
    end
  end

  assign snap   = rx_valid & ~phase_data & rx_byte[7];
  assign wr_en  = rx_valid & phase_data & ~is_read;
  assign rd_clr = rx_valid & phase_data & is_read & (addr == A_YH);

  gyro_spi_regfile #(.REV_ID(REV_ID), .SERIAL_NO(SERIAL_NO)) i_rf (
    .clk(clk), .rst_n(rst_n),
    .smp_valid(smp_valid), .smp(smp_in),
    .snap(snap),
    .wr_en(wr_en), .wr_addr(addr), .wr_data(rx_byte),
    .rd_addr(addr), .rd_clr(rd_clr), .rd_data(rd_data),
    .meas(meas), .drdy_out(drdy_out)
  );
endmodule

// File: rtl/gyro_spi_regs_chk.sv
module gyro_spi_regs_chk (
  input logic clk,
  input logic rst_n,
  input logic sel,
  input logic phase_data,
  input logic rx_valid,
  input logic tx_load,
  input logic wr_en,
  input logic rd_clr,
  input logic meas,
  input logic smp_valid,
  input logic drdy_out
);
  // R9: standby drops the pin by the next cycle
  p_standby_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !meas |=> !drdy_out);

  // R8: the pin only rises after a sample or a configuration write
  p_rise_cause_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(drdy_out) |-> ($past(smp_valid) || $past(wr_en)));

  // R8: the pin holds until the Y high byte has been read
  p_flag_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (drdy_out && meas && !rd_clr && !wr_en) |=> drdy_out);

  // R12: deselect ends the transaction
  p_deselect_reset_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !sel |=> !phase_data);

  // R4: a transmit load always follows a completed byte
  p_load_follows_byte_r4: assert property (@(posedge clk) disable iff (!rst_n)
    tx_load |-> $past(rx_valid));
endmodule

bind gyro_spi_regs gyro_spi_regs_chk i_chk (
  .clk(clk), .rst_n(rst_n), .sel(sel), .phase_data(phase_data),
  .rx_valid(rx_valid), .tx_load(tx_load), .wr_en(wr_en), .rd_clr(rd_clr),
  .meas(meas), .smp_valid(smp_valid), .drdy_out(drdy_out)
);

// File: tb/test_gyro_spi_regs.sv
`timescale 1ns/1ps
module test_gyro_spi_regs;
  localparam int HALF  = 8;
  localparam int LIMIT = 180000;
  localparam int NVEC  = 13;
  // {address, expected byte} for single-byte reads after reset
  localparam logic [15:0] RD_VEC [0:NVEC-1] = '{
    16'h00AD, 16'h011D, 16'h0292, 16'h0301, 16'h0434, 16'h0512, 16'h06C0,
    16'h075E, 16'h0800, 16'h0D00, 16'h1000, 16'h1100, 16'h1200};

  logic clk = 1'b0, rst_n = 1'b0;
  logic sclk = 1'b1, cs_n = 1'b1, mosi = 1'b0, miso;
  logic smp_valid = 1'b0, smp_ready, drdy;
  logic [15:0] sx = '0, sy = '0;
  logic [11:0] st = '0;
  logic [7:0] rbuf [0:7];
  int checks = 0, errors = 0;

  always #5 clk = ~clk;

  gyro_spi_regs i_gyro_spi_regs (
    .clk(clk), .rst_n(rst_n), .spi_sclk(sclk), .spi_cs_n(cs_n),
    .spi_mosi(mosi), .spi_miso(miso), .smp_valid(smp_valid),
    .smp_ready(smp_ready), .smp_rate_x(sx), .smp_rate_y(sy),
    .smp_temp(st), .drdy_out(drdy)
  );

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic spi_bits(input logic [7:0] tx, input int nb, output logic [7:0] rx);
    rx = '0;
    for (int i = 7; i > 7 - nb; i--) begin
      @(negedge clk); sclk = 1'b0; mosi = tx[i];
      repeat (HALF) @(negedge clk);
      rx[i] = miso; sclk = 1'b1;
      repeat (HALF) @(negedge clk);
    end
  endtask

  task automatic cs_lo(); @(negedge clk); cs_n = 1'b0; repeat (HALF) @(negedge clk); endtask
  task automatic cs_hi(); repeat (HALF) @(negedge clk); cs_n = 1'b1; repeat (2*HALF) @(negedge clk); endtask

  task automatic spi_read(input logic [6:0] a, input int n);
    logic [7:0] d;
    cs_lo();
    spi_bits({1'b1, a}, 8, d);
    for (int k = 0; k < n; k++) begin
      spi_bits(8'h00, 8, d);
      rbuf[k] = d;
    end
    cs_hi();
  endtask

  task automatic spi_write(input logic [6:0] a, input logic [7:0] v0, input logic [7:0] v1, input int n);
    logic [7:0] d;
    cs_lo();
    spi_bits({1'b0, a}, 8, d);
    spi_bits(v0, 8, d);
    if (n > 1) spi_bits(v1, 8, d);
    cs_hi();
  endtask

  task automatic push(input logic [15:0] x, input logic [15:0] y, input logic [11:0] t);
    @(negedge clk); sx = x; sy = y; st = t; smp_valid = 1'b1;
    @(negedge clk); smp_valid = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  task automatic chk6(input string req, input logic [47:0] exp);
    for (int k = 0; k < 6; k++) chk(req, {8'h00, rbuf[k]}, {8'h00, exp[47-8*k -: 8]});
  endtask

  initial begin
    repeat (LIMIT) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [7:0] d;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R7 reset pin", {15'd0, drdy}, 16'd0);
    chk("R14 ready", {15'd0, smp_ready}, 16'd1);
    chk("R1 miso idle", {15'd0, miso}, 16'd0);

    // table walk: R2 R3 R5 R6 R7 reset values
    for (int v = 0; v < NVEC; v++) begin
      spi_read(RD_VEC[v][14:8], 1);
      chk("R2/R3/R5/R6/R7 table", {8'h00, rbuf[0]}, {8'h00, RD_VEC[v][7:0]});
    end

    // R9: standby ignores samples
    spi_write(7'h12, 8'h01, 8'h00, 1);
    push(16'h8001, 16'h7F00, 12'h123);
    chk("R9 pin in standby", {15'd0, drdy}, 16'd0);
    spi_read(7'h08, 6);
    chk6("R9 data unchanged", 48'h0);

    // R5 R1 write then read
    spi_write(7'h10, 8'hFF, 8'h00, 1);
    spi_read(7'h10, 1);
    chk("R5 power mask", {8'h00, rbuf[0]}, 16'h0003);

    // R8 R11 R4: burst with a sample landing mid-read
    push(16'h1234, 16'hFEDC, 12'h8A5);
    chk("R8 pin set", {15'd0, drdy}, 16'd1);
    fork
      spi_read(7'h08, 6);
      begin repeat (250) @(negedge clk); push(16'h8001, 16'h7F00, 12'h123); end
    join
    chk6("R11 R4 R3 burst", 48'h3412DCFEA5F8);
    chk("R8 cleared by Y high", {15'd0, drdy}, 16'd0);
    spi_read(7'h08, 6);
    chk6("R11 next burst", 48'h0180007F2301);

    // R8 hold until 0x0B
    push(16'h1234, 16'hFEDC, 12'h8A5);
    spi_read(7'h08, 3);
    chk("R8 hold before Y high", {15'd0, drdy}, 16'd1);
    spi_read(7'h0B, 1);
    chk("R8 clear at Y high", {15'd0, drdy}, 16'd0);
    chk("R3 Y high byte", {8'h00, rbuf[0]}, 16'h00FE);

    // R10: temperature disabled
    spi_write(7'h10, 8'h02, 8'h00, 1);
    push(16'h0102, 16'h0304, 12'h7FF);
    spi_read(7'h08, 6);
    chk6("R10 temp frozen", 48'h02010403A5F8);
    spi_write(7'h10, 8'h03, 8'h00, 1);

    // R7 routing
    push(16'h0102, 16'h0304, 12'h7FF);
    chk("R7 routed", {15'd0, drdy}, 16'd1);
    spi_write(7'h12, 8'h02, 8'h00, 1);
    chk("R7 unrouted", {15'd0, drdy}, 16'd0);
    spi_read(7'h12, 1);
    chk("R7 cfg readback", {8'h00, rbuf[0]}, 16'h0002);
    spi_write(7'h12, 8'h01, 8'h00, 1);
    chk("R7 rerouted", {15'd0, drdy}, 16'd1);

    // R13: read-only writes, R4 write auto-increment
    spi_write(7'h00, 8'h55, 8'h00, 1);
    spi_read(7'h00, 1);
    chk("R13 id kept", {8'h00, rbuf[0]}, 16'h00AD);
    spi_write(7'h08, 8'h77, 8'h00, 1);
    spi_read(7'h08, 1);
    chk("R13 data kept", {8'h00, rbuf[0]}, 16'h0002);
    spi_write(7'h11, 8'h73, 8'hFF, 2);
    spi_read(7'h11, 2);
    chk("R4 write step flt", {8'h00, rbuf[0]}, 16'h0073);
    chk("R4 write step drc", {8'h00, rbuf[1]}, 16'h0003);
    chk("R7 pin off at 11", {15'd0, drdy}, 16'd0);

    // R12: partial byte aborted
    cs_lo();
    spi_bits(8'h11, 8, d);
    spi_bits(8'h05, 4, d);
    cs_hi();
    spi_read(7'h11, 1);
    chk("R12 partial write dropped", {8'h00, rbuf[0]}, 16'h0073);
    cs_lo();
    spi_bits(8'hFF, 3, d);
    cs_hi();
    spi_read(7'h00, 1);
    chk("R12 fresh command", {8'h00, rbuf[0]}, 16'h00AD);

    // R6 mask
    spi_write(7'h11, 8'hFF, 8'h00, 1);
    spi_read(7'h11, 1);
    chk("R6 bit3 zero", {8'h00, rbuf[0]}, 16'h00F7);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule